// File: doc/BRIEF.md
# Flash Whole-Device Erase Sequencer

This block runs the complete erase procedure for a byte-wide flash array. It is a host-side master of a simple command bus. After a start pulse it raises the high-voltage enable. It then clears every byte to 00h with program and program-check cycles, retrying each byte a bounded number of times. Next it issues erase pulses and checks the array byte by byte for the erased value FFh.

When a byte fails the check, the sequencer records the retry and fires one more erase pulse. It then carries on checking from that same byte, so bytes that already passed are not read again. The run ends in pass or fail. The result stays on the outputs until the next start. Every wait (program settle, check settle, erase pulse) is a count of clock cycles given by a parameter. The erase retry limit is picked from two parameters by a grade setting.

The command bus moves one transfer per cycle in which `bus_en` is high. A write carries `bus_wdata` and `bus_addr`. The device answers a read in the following cycle on `bus_rdata`, and holds that value until the next read.

Top module: `erase_algo_seq`

## Requirements
- R1: With the block idle, a start pulse sets busy and vpp_en high, clears done, pass and fail, and begins at address 0. A start pulse while busy is ignored.
- R2: Pre-program pass: for each address from 0 upward, the block writes 40h, then writes 00h at that address, then waits T_PROG idle cycles. It then writes C0h, waits T_VFY idle cycles and reads. A read of 00h moves on to the next address. Any other value repeats the byte. After PROG_MAX program writes on one byte without reading 00h, the run ends as a failure.
- R3: No erase pulse is issued before every byte has read back 00h.
- R4: An erase pulse consists of two writes of 20h in consecutive cycles, followed by exactly T_ERASE idle cycles before the next transfer.
- R5: Erase check of a byte: a write of A0h carrying the byte address, exactly T_VFY idle cycles, then a read. The byte passes only if the read returns FFh.
- R6: Erase checking starts at address 0, goes upward one address at a time, and ends after the last address (all ones) passes.
- R7: On a failed erase check the block issues another erase pulse at once, with no other command in between. Checking then resumes at the failing address.
- R8: The erase retry limit is LIMIT_EXT when EXT_GRADE is 1 and LIMIT_STD otherwise. If a check fails after the limit number of erase pulses, the run ends as a failure: no more pulses, no 00h write, vpp_en low.
- R9: When the last address passes, the block writes 00h once with vpp_en still high. In the next cycle vpp_en goes low, and done and pass go high.
- R10: done, pass and fail hold their values until the next accepted start. done is high exactly when one of pass or fail is high, and never while busy.
- R11: bus_en is only high while vpp_en is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start request, accepted when idle |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Last run finished (held) |
| pass | output | 1 | Last run erased the whole array (held) |
| fail | output | 1 | Last run gave up (held) |
| vpp_en | output | 1 | Enable for the programming voltage supply |
| bus_en | output | 1 | Command bus transfer this cycle |
| bus_wr | output | 1 | 1 = write transfer, 0 = read transfer |
| bus_addr | output | ADDR_W | Byte address of the transfer |
| bus_wdata | output | 8 | Command or data byte for writes |
| bus_rdata | input | 8 | Read data, valid the cycle after a read |

## Verification
The hardest state to reach from the ports is an erase that stalls partway through the array. It must fail the check several times at one byte, keep earlier bytes untouched, and then either finish within the retry limit or hit it exactly. The bench drives this with a behavioural flash model in which each byte needs its own number of erase pulses and program writes. Those counts are drawn with a fixed seed, and directed cases place the worst byte exactly at the limit and one beyond it. The model itself flags wrong command order, wrong idle gaps and checks out of sequence.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

  typedef enum logic [4:0] {
    S_IDLE,
    S_PSET,
    S_PDAT,
    S_PWAIT,
    S_PVSET,
    S_PVWAIT,
    S_PRD,
    S_PCHK,
    S_ESET1,
    S_ESET2,
    S_EWAIT,
    S_VSET,
    S_VWAIT,
    S_VRD,
    S_VCHK,
    S_RDCMD
  } seq_state_e;

  localparam logic [7:0] CMD_READ    = 8'h00;
  localparam logic [7:0] CMD_ERASE   = 8'h20;
  localparam logic [7:0] CMD_PROG    = 8'h40;
  localparam logic [7:0] CMD_EVFY    = 8'hA0;
  localparam logic [7:0] CMD_PVFY    = 8'hC0;
  localparam logic [7:0] BYTE_CLEAR  = 8'h00;
  localparam logic [7:0] BYTE_ERASED = 8'hFF;

endpackage

// File: rtl/seq_wait_timer.sv
module seq_wait_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_en = load || (cnt_q != '0);
    cnt_d  = load ? load_val : cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/seq_limit_counter.sv
module seq_limit_counter #(
  parameter int LIMIT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic inc,
  output logic at_last
);

  localparam int CW = $clog2(LIMIT + 1);

  logic [CW-1:0] count_q;
  logic [CW-1:0] count_d;
  logic          count_en;

  always_comb begin
    count_en = clr || inc;
    count_d  = clr ? '0 : count_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
    end else if (count_en) begin
      count_q <= count_d;
    end
  end

  assign at_last = (count_q == CW'(LIMIT - 1));

endmodule

// File: rtl/erase_algo_seq.sv
module erase_algo_seq
  import flash_seq_pkg::*;
#(
  parameter int ADDR_W    = 17,
  parameter int T_PROG    = 2000,
  parameter int T_VFY     = 1200,
  parameter int T_ERASE   = 2000000,
  parameter int PROG_MAX  = 25,
  parameter int LIMIT_STD = 1000,
  parameter int LIMIT_EXT = 6000,
  parameter bit EXT_GRADE = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              busy,
  output logic              done,
  output logic              pass,
  output logic              fail,
  output logic              vpp_en,
  output logic              bus_en,
  output logic              bus_wr,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [7:0]        bus_wdata,
  input  logic [7:0]        bus_rdata
);

  localparam int RETRY_LIMIT = EXT_GRADE ? LIMIT_EXT : LIMIT_STD;
  localparam int T_PV_MAX    = (T_PROG > T_VFY) ? T_PROG : T_VFY;
  localparam int T_MAX       = (T_ERASE > T_PV_MAX) ? T_ERASE : T_PV_MAX;
  localparam int TMR_W       = $clog2(T_MAX + 1);
  localparam logic [ADDR_W-1:0] LAST_ADDR = {ADDR_W{1'b1}};

  seq_state_e        state_q, state_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              vpp_q, vpp_d;
  logic              done_q, done_d;
  logic              pass_q, pass_d;
  logic              fail_q, fail_d;

  logic              tmr_load;
  logic [TMR_W-1:0]  tmr_val;
  logic              tmr_expired;
  logic              pc_clr, pc_inc, pc_last;
  logic              ec_clr, ec_inc, ec_last;

  seq_wait_timer #(.W(TMR_W)) i_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (tmr_load),
    .load_val(tmr_val),
    .expired (tmr_expired)
  );

  seq_limit_counter #(.LIMIT(PROG_MAX)) i_prog_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (pc_clr),
    .inc    (pc_inc),
    .at_last(pc_last)
  );

  seq_limit_counter #(.LIMIT(RETRY_LIMIT)) i_erase_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (ec_clr),
    .inc    (ec_inc),
    .at_last(ec_last)
  );

  always_comb begin
    state_d   = state_q;
    addr_d    = addr_q;
    vpp_d     = vpp_q;
    done_d    = done_q;
    pass_d    = pass_q;
    fail_d    = fail_q;
    tmr_load  = 1'b0;
    tmr_val   = '0;
    pc_clr    = 1'b0;
    pc_inc    = 1'b0;
    ec_clr    = 1'b0;
    ec_inc    = 1'b0;
    bus_en    = 1'b0;
    bus_wr    = 1'b0;
    bus_addr  = addr_q;
    bus_wdata = 8'h00;

    unique case (state_q)
      S_IDLE: begin
        if (start) begin
          state_d = S_PSET;
          addr_d  = '0;
          vpp_d   = 1'b1;
          done_d  = 1'b0;
          pass_d  = 1'b0;
          fail_d  = 1'b0;
          pc_clr  = 1'b1;
          ec_clr  = 1'b1;
        end
      end
      S_PSET: begin
        bus_en    = 1'b1;
        bus_wr    = 1'b1;
        bus_wdata = CMD_PROG;
        state_d   = S_PDAT;
      end
      S_PDAT: begin
        bus_en    = 1'b1;
        bus_wr    = 1'b1;
        bus_wdata = BYTE_CLEAR;
        tmr_load  = 1'b1;
        tmr_val   = TMR_W'(T_PROG - 1);
        state_d   = S_PWAIT;
      end
      S_PWAIT: begin
        if (tmr_expired) state_d = S_PVSET;
      end
      S_PVSET: begin
        bus_en    = 1'b1;
        bus_wr    = 1'b1;
        bus_wdata = CMD_PVFY;
        tmr_load  = 1'b1;
        tmr_val   = TMR_W'(T_VFY - 1);
        state_d   = S_PVWAIT;
      end
      S_PVWAIT: begin
        if (tmr_expired) state_d = S_PRD;
      end
      S_PRD: begin
        bus_en  = 1'b1;
        state_d = S_PCHK;
      end
      S_PCHK: begin
        if (bus_rdata == BYTE_CLEAR) begin
          pc_clr = 1'b1;
          if (addr_q == LAST_ADDR) begin
            addr_d  = '0;
            state_d = S_ESET1;
          end else begin
            addr_d  = addr_q + 1'b1;
            state_d = S_PSET;
          end
        end else if (pc_last) begin
          state_d = S_IDLE;
          vpp_d   = 1'b0;
          done_d  = 1'b1;
          fail_d  = 1'b1;
        end else begin
          pc_inc  = 1'b1;
          state_d = S_PSET;
        end
      end
      S_ESET1: begin
        bus_en    = 1'b1;
        bus_wr    = 1'b1;
        bus_wdata = CMD_ERASE;
        state_d   = S_ESET2;
      end
      S_ESET2: begin
        bus_en    = 1'b1;
        bus_wr    = 1'b1;
        bus_wdata = CMD_ERASE;
        tmr_load  = 1'b1;
        tmr_val   = TMR_W'(T_ERASE - 1);
        state_d   = S_EWAIT;
      end
      S_EWAIT: begin
        if (tmr_expired) state_d = S_VSET;
      end
      S_VSET: begin
        bus_en    = 1'b1;
        bus_wr    = 1'b1;
        bus_wdata = CMD_EVFY;
        tmr_load  = 1'b1;
        tmr_val   = TMR_W'(T_VFY - 1);
        state_d   = S_VWAIT;
      end
      S_VWAIT: begin
        if (tmr_expired) state_d = S_VRD;
      end
      S_VRD: begin
        bus_en  = 1'b1;
        state_d = S_VCHK;
      end
      S_VCHK: begin
        if (bus_rdata == BYTE_ERASED) begin
          if (addr_q == LAST_ADDR) begin
            state_d = S_RDCMD;
          end else begin
            addr_d  = addr_q + 1'b1;
            state_d = S_VSET;
          end
        end else if (ec_last) begin
          state_d = S_IDLE;
          vpp_d   = 1'b0;
          done_d  = 1'b1;
          fail_d  = 1'b1;
        end else begin
          ec_inc  = 1'b1;
          state_d = S_ESET1;
        end
      end
      S_RDCMD: begin
        bus_en    = 1'b1;
        bus_wr    = 1'b1;
        bus_wdata = CMD_READ;
        state_d   = S_IDLE;
        vpp_d     = 1'b0;
        done_d    = 1'b1;
        pass_d    = 1'b1;
      end
      default: begin
        state_d = S_IDLE;
        vpp_d   = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      addr_q  <= '0;
      vpp_q   <= 1'b0;
      done_q  <= 1'b0;
      pass_q  <= 1'b0;
      fail_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      addr_q  <= addr_d;
      vpp_q   <= vpp_d;
      done_q  <= done_d;
      pass_q  <= pass_d;
      fail_q  <= fail_d;
    end
  end

  assign busy   = (state_q != S_IDLE);
  assign done   = done_q;
  assign pass   = pass_q;
  assign fail   = fail_q;
  assign vpp_en = vpp_q;

endmodule

// File: rtl/erase_algo_seq_chk.sv
module erase_algo_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       busy,
  input logic       done,
  input logic       pass,
  input logic       fail,
  input logic       vpp_en,
  input logic       bus_en,
  input logic       bus_wr,
  input logic [7:0] bus_wdata
);

  assert_bus_needs_vpp_R11: assert property (@(posedge clk) disable iff (!rst_n)
    bus_en |-> vpp_en);

  assert_result_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({pass, fail}) && (done == (pass || fail)));

  assert_busy_not_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !done);

  assert_result_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> (done && $stable(pass) && $stable(fail)));

  assert_start_accept_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (busy && vpp_en && !done));

  assert_vpp_off_when_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !vpp_en);

  assert_read_cmd_before_pass_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pass) |-> $past(bus_en && bus_wr && (bus_wdata == 8'h00)));

endmodule

bind erase_algo_seq erase_algo_seq_chk i_erase_algo_seq_chk (.*);

// File: tb/test_erase_algo_seq.sv
`timescale 1ns/1ps
module test_erase_algo_seq;

  localparam int AW  = 3;
  localparam int NB  = 1 << AW;
  localparam int TP  = 5;
  localparam int TV  = 3;
  localparam int TE  = 12;
  localparam int PM  = 3;
  localparam int LS  = 4;
  localparam int LE  = 7;
  localparam int LIM = LE;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic          busy, done, pass, fail, vpp_en;
  logic          bus_en, bus_wr;
  logic [AW-1:0] bus_addr;
  logic [7:0]    bus_wdata;
  logic [7:0]    bus_rdata = 8'h00;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  erase_algo_seq #(
    .ADDR_W(AW), .T_PROG(TP), .T_VFY(TV), .T_ERASE(TE),
    .PROG_MAX(PM), .LIMIT_STD(LS), .LIMIT_EXT(LE), .EXT_GRADE(1'b1)
  ) i_erase_algo_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .pass(pass), .fail(fail), .vpp_en(vpp_en), .bus_en(bus_en),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata)
  );

  // Behavioural flash model with protocol monitors
  logic [7:0] mem [NB];
  int resist [NB];
  int pneed  [NB];
  int ppul   [NB];
  int idle, exp_gap, gap_tag, pend, vaddr, plast, exp_v;
  bit need_erase;
  int m_erase, m_vreads, m_rdcmd;
  int v_r2, v_r3, v_r4, v_r5, v_r6, v_r7, v_r11;

  task automatic model_clear();
    for (int a = 0; a < NB; a++) begin
      mem[a] = 8'h5A;
      ppul[a] = 0;
    end
    exp_gap = -1; gap_tag = 0; pend = 0; vaddr = 0; plast = 0; exp_v = 0;
    need_erase = 1'b0;
    m_erase = 0; m_vreads = 0; m_rdcmd = 0;
    v_r2 = 0; v_r3 = 0; v_r4 = 0; v_r5 = 0; v_r6 = 0; v_r7 = 0; v_r11 = 0;
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      idle = 0;
    end else if (bus_en) begin
      if (!vpp_en) v_r11++;
      if (exp_gap >= 0 && idle != exp_gap) begin
        if (gap_tag == 2) v_r2++;
        else if (gap_tag == 4) v_r4++;
        else v_r5++;
      end
      exp_gap = -1;
      idle = 0;
      if (bus_wr) begin
        if (pend == 1) begin
          ppul[bus_addr]++;
          if (ppul[bus_addr] >= pneed[bus_addr]) mem[bus_addr] = mem[bus_addr] & bus_wdata;
          plast = int'(bus_addr);
          pend = 0; exp_gap = TP; gap_tag = 2;
        end else begin
          case (bus_wdata)
            8'h20: begin
              if (pend == 2) begin
                if (m_erase == 0)
                  for (int a = 0; a < NB; a++) if (mem[a] != 8'h00) v_r3++;
                m_erase++;
                for (int a = 0; a < NB; a++) if (m_erase >= resist[a]) mem[a] = 8'hFF;
                need_erase = 1'b0;
                pend = 0; exp_gap = TE; gap_tag = 4;
              end else begin
                pend = 2; exp_gap = 0; gap_tag = 4;
              end
            end
            8'h40: begin
              if (need_erase) v_r7++;
              if (m_erase != 0) v_r3++;
              pend = 1;
            end
            8'hA0: begin
              if (need_erase) v_r7++;
              if (int'(bus_addr) != exp_v) v_r6++;
              vaddr = int'(bus_addr);
              pend = 3; exp_gap = TV; gap_tag = 5;
            end
            8'hC0: begin
              pend = 4; exp_gap = TV; gap_tag = 2;
            end
            8'h00: begin
              m_rdcmd++;
              if (exp_v != NB) v_r6++;
              pend = 0;
            end
            default: begin
              v_r2++;
              pend = 0;
            end
          endcase
        end
      end else begin
        if (pend == 3) begin
          bus_rdata <= mem[vaddr];
          m_vreads++;
          if (mem[vaddr] == 8'hFF) exp_v++;
          else need_erase = 1'b1;
        end else if (pend == 4) begin
          bus_rdata <= mem[plast];
        end else begin
          v_r2++;
        end
        pend = 0;
      end
    end else begin
      idle++;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int max_resist();
    int m = 0;
    for (int a = 0; a < NB; a++) if (resist[a] > m) m = resist[a];
    return m;
  endfunction

  function automatic bit prog_fails();
    for (int a = 0; a < NB; a++) if (pneed[a] > PM) return 1'b1;
    return 1'b0;
  endfunction

  function automatic int prog_sum();
    int s = 0;
    for (int a = 0; a < NB; a++) s += pneed[a];
    return s;
  endfunction

  task automatic run_case(input int restart_at);
    int  cyc;
    bit  pf, exp_pass;
    int  mr, exp_pulses, got_pp;
    model_clear();
    pf = prog_fails();
    mr = max_resist();
    exp_pass = !pf && (mr <= LIM);
    exp_pulses = pf ? 0 : ((mr < LIM) ? mr : LIM);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    check(busy && vpp_en && !done && !pass && !fail, "R1 start accepted", int'(busy), 1);
    cyc = 0;
    while (!done && cyc < 20000) begin
      @(negedge clk);
      cyc++;
      if (restart_at > 0 && cyc == restart_at) start = 1'b1;
      else start = 1'b0;
    end
    start = 1'b0;
    check(cyc < 20000, "watchdog", cyc, 20000);
    got_pp = 0;
    for (int a = 0; a < NB; a++) got_pp += ppul[a];
    if (exp_pass) begin
      check(pass && !fail && done, "R9 pass reported", int'(pass), 1);
      check(m_rdcmd == 1, "R9 single read command", m_rdcmd, 1);
      check(m_vreads == NB + exp_pulses - 1, "R7 resume from failing byte", m_vreads, NB + exp_pulses - 1);
      check(got_pp == prog_sum(), "R2 program writes per byte", got_pp, prog_sum());
    end else begin
      check(fail && !pass && done, "R8 fail reported", int'(fail), 1);
      check(m_rdcmd == 0, "R8 no read command on fail", m_rdcmd, 0);
    end
    check(m_erase == exp_pulses, pf ? "R3 no erase after program fail" : "R8 erase pulse count",
          m_erase, exp_pulses);
    check(!vpp_en && !busy, "R9 vpp_en dropped", int'(vpp_en), 0);
    check(v_r2 == 0, "R2 program sequence", v_r2, 0);
    check(v_r3 == 0, "R3 preprogram before erase", v_r3, 0);
    check(v_r4 == 0, "R4 erase pulse shape", v_r4, 0);
    check(v_r5 == 0, "R5 check gap", v_r5, 0);
    check(v_r6 == 0, "R6 check order", v_r6, 0);
    check(v_r7 == 0, "R7 erase after mismatch", v_r7, 0);
    check(v_r11 == 0, "R11 bus only with vpp", v_r11, 0);
  endtask

  task automatic set_all(input int r, input int p);
    for (int a = 0; a < NB; a++) begin
      resist[a] = r;
      pneed[a] = p;
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    set_all(1, 1);
    model_clear();
    repeat (3) @(negedge clk);
    check(!busy && !done && !pass && !fail && !vpp_en && !bus_en, "R1 reset state", int'(busy), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // Directed: everything erases on the first pulse
    set_all(1, 1);
    run_case(0);
    repeat (30) @(negedge clk);
    check(done && pass && !fail, "R10 result held", int'(pass), 1);

    // First byte stubborn, last byte at the limit exactly
    set_all(1, 1);
    resist[0] = 3;
    resist[NB-1] = LIM;
    run_case(0);

    // One byte beyond the limit
    set_all(2, 1);
    resist[2] = LIM + 1;
    run_case(0);
    check(ppul[0] == 1, "R2 one program write when byte clears", ppul[0], 1);

    // A byte that never programs
    set_all(1, 1);
    pneed[5] = PM + 1;
    run_case(0);
    check(ppul[5] == PM, "R2 program retry limit", ppul[5], PM);
    check(ppul[6] == 0, "R2 stop after program fail", ppul[6], 0);

    // Constrained random runs, one with a start pulse while busy
    for (int k = 0; k < 5; k++) begin
      for (int a = 0; a < NB; a++) begin
        resist[a] = 1 + int'($urandom % LIM);
        pneed[a]  = 1 + int'($urandom % PM);
      end
      run_case(k == 1 ? 40 : 0);
    end
    check(done && pass, "R1 start while busy ignored", int'(pass), 1);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule